// File: doc/BRIEF.md
# Block-Oriented HDLC Receive Pool

This block stores the bytes an HDLC deframer has recovered and hands them to a host processor in fixed-size blocks. The deframer pushes one byte per cycle, flags the final byte of each frame, and reports the CRC verdict and any abort with that final byte. The host waits for an interrupt, reads the exposed block through a byte port, and then issues a release command. The release frees the block's storage and lets the next block be announced.

Storage is a 64-byte circular buffer divided into slots of one block each. The block size is 4, 8, 16 or 32 bytes. A block is exposed as a "pool full" block when more of the same frame follows it. It is exposed as a "message end" block when it holds the last bytes of the frame. A frame that arrives while every slot is occupied is thrown away whole, and an overflow interrupt is raised. A frame that runs out of slots partway through keeps what was stored, has its last block marked aborted, and also raises overflow. A receiver-reset command empties the buffer and applies a new block size.

Top module: `hrx_pool`

## Requirements
- R1: After power-up reset, all three interrupt outputs are low and rx_count and rx_status read 0.
- R2: The block size is 4, 8, 16 or 32 bytes for cfg_bsize values 0, 1, 2 and 3. It is 4 after power-up reset, and cfg_bsize is taken in only in a cycle where cmd_reset is high. A change of cfg_bsize at any other time has no effect.
- R3: A frame no longer than one block raises irq_msg_end with rx_count equal to its length. rx_status bit 1 holds the frame's CRC-good flag and bit 0 holds its abort flag.
- R4: A frame longer than one block is exposed as a series of full blocks, each raising irq_pool_full with rx_count equal to the block size. Its final part raises irq_msg_end with a count from 1 up to the block size. A frame whose length is an exact multiple of the block size ends with a count equal to the block size.
- R5: Only one block is exposed at a time. irq_pool_full and irq_msg_end are never high together. No further data interrupt appears until the host releases the exposed block, even when later blocks are already stored.
- R6: cmd_release has no effect while no block is exposed. The next stored frame is still exposed and read correctly.
- R7: rd_data shows the byte at the current offset of the exposed block, starting at offset 0. A one-cycle rd_en pulse moves to the next byte. Once the last valid byte is reached, further rd_en pulses keep showing that byte.
- R8: When a frame's first byte arrives and no slot is free, the whole frame is discarded and nothing of it is stored. irq_overflow rises when its final byte arrives.
- R9: When a frame needs a further slot and none is free, the rest of the frame is discarded and irq_overflow rises at its end. The stored blocks remain readable, and the last stored block is exposed as a message end with rx_status bit 0 (abort) set and a count equal to the block size.
- R10: irq_ack clears all three interrupt outputs. The exposed block, its rx_count and its read position stay as they are.
- R11: Slots are reused in circular order. Frames keep reading back intact after the slot pointer has wrapped past the end of the buffer many times.
- R12: cmd_reset discards every stored byte and clears all interrupts and rx_count in the next cycle. A frame that starts after it is stored from the first free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bsize | input | 2 | Block size code, taken in when cmd_reset is high |
| wr_valid | input | 1 | A received byte is present on wr_data |
| wr_data | input | 8 | Received byte |
| wr_last | input | 1 | This byte ends the frame |
| wr_crc_ok | input | 1 | Frame CRC was good (with wr_last) |
| wr_abort | input | 1 | Frame was aborted (with wr_last) |
| cmd_release | input | 1 | Host has read the exposed block, free it |
| cmd_reset | input | 1 | Receiver reset: empty buffer, apply cfg_bsize |
| irq_ack | input | 1 | Clear all interrupt outputs |
| rd_en | input | 1 | Advance to next byte of the exposed block |
| rd_data | output | 8 | Byte at current read position |
| rx_count | output | 6 | Valid bytes in the exposed block, 0 when none |
| rx_status | output | 2 | {CRC good, abort} of a message-end block |
| irq_pool_full | output | 1 | Full block exposed, frame continues |
| irq_msg_end | output | 1 | Final block of a frame exposed |
| irq_overflow | output | 1 | A frame was dropped or cut short |

## Verification
The bench builds the block with its default 64-byte buffer. This gives 16 slots at the smallest block size and only two at the largest. With 32-byte blocks, two stored frames are enough to fill every slot, so both the whole-frame drop and the mid-frame cut-off can be reached with short stimulus. With 4-byte blocks, twenty short frames take the slot pointer around the buffer more than once. Every block size code is exercised, including a mode change without the reset command, and the exact-multiple and one-byte-over lengths at the block boundary.

// File: rtl/hrx_pkg.sv
`timescale 1ns/1ps
package hrx_pkg;
  localparam int LEN_W = 6;

  typedef logic [1:0] bsel_t;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             last;
    logic             crc_ok;
    logic             abort;
  } blk_desc_t;

  // bytes per block for a size code: 4 << code
  function automatic logic [LEN_W-1:0] blk_bytes(input bsel_t sel);
    return LEN_W'(4) << sel;
  endfunction

  // number of block slots the buffer holds at a size code
  function automatic int unsigned slot_total(input int unsigned depth, input bsel_t sel);
    return depth >> (32'(sel) + 2);
  endfunction

  // byte address of offset off inside slot s
  function automatic logic [15:0] byte_addr(input logic [15:0] s, input bsel_t sel,
                                            input logic [LEN_W-1:0] off);
    return (s << (32'(sel) + 2)) + 16'(off);
  endfunction
endpackage

// File: rtl/hrx_writer.sv
`timescale 1ns/1ps
module hrx_writer
  import hrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(DEPTH / 4)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  bsel_t         sel,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          wr_last,
  input  logic          wr_crc_ok,
  input  logic          wr_abort,
  input  logic          rel,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          fill_pub,
  output logic [SW-1:0] fill_slot,
  output blk_desc_t     fill_desc,
  output logic          end_pub,
  output logic [SW-1:0] end_slot,
  output blk_desc_t     end_desc,
  output logic          ovf_evt,
  output logic          drop_start,
  output logic          drop_act,
  output logic [SW:0]   occ_o
);
  logic             in_frame, dropping, trunc;
  logic [SW-1:0]    cur, tail;
  logic [LEN_W-1:0] wlen;
  logic [SW:0]      occ;

  logic [LEN_W-1:0] bsz;
  logic [SW:0]      nsl;
  logic [SW-1:0]    smask;
  assign bsz   = blk_bytes(sel);
  assign nsl   = (SW+1)'(slot_total(DEPTH, sel));
  assign smask = SW'(nsl - 1'b1);

  logic space_ok, start, open_w, need_new, alloc, go_trunc, take, fin;
  assign space_ok   = occ < nsl;
  assign start      = wr_valid && !in_frame;
  assign open_w     = wr_valid && in_frame && !dropping && !trunc;
  assign need_new   = open_w && (wlen == bsz);
  assign alloc      = (start || need_new) && space_ok && !clr;
  assign drop_start = start && !space_ok;
  assign go_trunc   = need_new && !space_ok;
  assign take       = alloc || (open_w && !need_new && !clr);
  assign fin        = wr_valid && wr_last && !clr;

  assign mem_we    = take;
  assign mem_wdata = wr_data;
  assign mem_waddr = alloc ? AW'(byte_addr(16'(tail), sel, '0))
                           : AW'(byte_addr(16'(cur), sel, wlen));

  // a full block is published only once the frame is known to continue
  assign fill_pub  = need_new && space_ok && !clr;
  assign fill_slot = cur;
  assign fill_desc = '{len: bsz, last: 1'b0, crc_ok: 1'b0, abort: 1'b0};

  assign end_pub   = fin && !dropping && !drop_start;
  assign end_slot  = alloc ? tail : cur;
  assign end_desc  = '{len:    alloc ? LEN_W'(1) : (take ? wlen + 1'b1 : wlen),
                       last:   1'b1,
                       crc_ok: wr_crc_ok,
                       abort:  wr_abort || trunc || go_trunc};
  assign ovf_evt   = fin && (dropping || drop_start || trunc || go_trunc);
  assign drop_act  = dropping;
  assign occ_o     = occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      dropping <= 1'b0;
      trunc    <= 1'b0;
      cur      <= '0;
      tail     <= '0;
      wlen     <= '0;
      occ      <= '0;
    end else if (clr) begin
      in_frame <= 1'b0;
      dropping <= 1'b0;
      trunc    <= 1'b0;
      cur      <= '0;
      tail     <= '0;
      wlen     <= '0;
      occ      <= '0;
    end else begin
      if (wr_valid) begin
        in_frame <= !wr_last;
        dropping <= !wr_last && (dropping || drop_start);
        trunc    <= !wr_last && (trunc || go_trunc);
      end
      if (alloc) begin
        cur  <= tail;
        tail <= (tail + 1'b1) & smask;
        wlen <= LEN_W'(1);
      end else if (take) begin
        wlen <= wlen + 1'b1;
      end
      occ <= occ + {{SW{1'b0}}, alloc} - {{SW{1'b0}}, rel};
    end
  end
endmodule

// File: rtl/hrx_store.sv
`timescale 1ns/1ps
module hrx_store
  import hrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(DEPTH / 4),
  localparam int NS = DEPTH / 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic          fill_pub,
  input  logic [SW-1:0] fill_slot,
  input  blk_desc_t     fill_desc,
  input  logic          end_pub,
  input  logic [SW-1:0] end_slot,
  input  blk_desc_t     end_desc,
  input  logic          rel,
  input  logic [SW-1:0] head_slot,
  output logic          head_ready,
  output blk_desc_t     head_desc
);
  logic [7:0] mem [DEPTH];
  logic       rdy [NS];
  blk_desc_t  desc [NS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];

  for (genvar g = 0; g < NS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy[g]  <= 1'b0;
        desc[g] <= '0;
      end else if (clr) begin
        rdy[g] <= 1'b0;
      end else if (fill_pub && fill_slot == SW'(g)) begin
        rdy[g]  <= 1'b1;
        desc[g] <= fill_desc;
      end else if (end_pub && end_slot == SW'(g)) begin
        rdy[g]  <= 1'b1;
        desc[g] <= end_desc;
      end else if (rel && head_slot == SW'(g)) begin
        rdy[g] <= 1'b0;
      end
    end
  end

  assign head_ready = rdy[head_slot];
  assign head_desc  = desc[head_slot];
endmodule

// File: rtl/hrx_host.sv
`timescale 1ns/1ps
module hrx_host
  import hrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(DEPTH / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  bsel_t            sel,
  input  logic             head_ready,
  input  blk_desc_t        head_desc,
  input  logic             cmd_release,
  input  logic             irq_ack,
  input  logic             rd_en,
  input  logic             ovf_evt,
  output logic             rel,
  output logic [SW-1:0]    rslot,
  output logic [AW-1:0]    rd_addr,
  output logic [LEN_W-1:0] rx_count,
  output logic [1:0]       rx_status,
  output logic             irq_pf,
  output logic             irq_me,
  output logic             irq_ov,
  output logic             shown,
  output logic [LEN_W-1:0] rd_off
);
  logic [SW-1:0] smask;
  assign smask = SW'(slot_total(DEPTH, sel) - 1);

  logic present_evt, adv;
  assign present_evt = head_ready && !shown && !clr;
  assign rel         = cmd_release && shown && !clr;
  assign adv         = rd_en && shown && ((rd_off + 1'b1) < head_desc.len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown  <= 1'b0;
      rslot  <= '0;
      rd_off <= '0;
      irq_pf <= 1'b0;
      irq_me <= 1'b0;
      irq_ov <= 1'b0;
    end else if (clr) begin
      shown  <= 1'b0;
      rslot  <= '0;
      rd_off <= '0;
      irq_pf <= 1'b0;
      irq_me <= 1'b0;
      irq_ov <= 1'b0;
    end else begin
      if (rel)              shown <= 1'b0;
      else if (present_evt) shown <= 1'b1;
      if (rel) rslot <= (rslot + 1'b1) & smask;
      if (rel || present_evt) rd_off <= '0;
      else if (adv)           rd_off <= rd_off + 1'b1;
      if (present_evt && !head_desc.last) irq_pf <= 1'b1;
      else if (irq_ack || rel)            irq_pf <= 1'b0;
      if (present_evt && head_desc.last)  irq_me <= 1'b1;
      else if (irq_ack || rel)            irq_me <= 1'b0;
      if (ovf_evt)      irq_ov <= 1'b1;
      else if (irq_ack) irq_ov <= 1'b0;
    end
  end

  assign rd_addr   = AW'(byte_addr(16'(rslot), sel, rd_off));
  assign rx_count  = shown ? head_desc.len : '0;
  assign rx_status = (shown && head_desc.last) ? {head_desc.crc_ok, head_desc.abort} : 2'b00;
endmodule

// File: rtl/hrx_pool.sv
`timescale 1ns/1ps
module hrx_pool
  import hrx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_bsize,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  input  logic       wr_crc_ok,
  input  logic       wr_abort,
  input  logic       cmd_release,
  input  logic       cmd_reset,
  input  logic       irq_ack,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [5:0] rx_count,
  output logic [1:0] rx_status,
  output logic       irq_pool_full,
  output logic       irq_msg_end,
  output logic       irq_overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(DEPTH / 4);

  bsel_t bs_sel;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bs_sel <= 2'b00;
    else if (cmd_reset) bs_sel <= cfg_bsize;
  end

  logic             mem_we, fill_pub, end_pub, ovf_evt, drop_start, drop_act;
  logic [AW-1:0]    mem_waddr, rd_addr;
  logic [7:0]       mem_wdata;
  logic [SW-1:0]    fill_slot, end_slot, rslot;
  blk_desc_t        fill_desc, end_desc, head_desc;
  logic [SW:0]      occ;
  logic             rel, head_ready, shown;
  logic [LEN_W-1:0] rd_off, cnt;

  hrx_writer #(.DEPTH(DEPTH)) u_wr (
    .clk, .rst_n, .clr(cmd_reset), .sel(bs_sel),
    .wr_valid, .wr_data, .wr_last, .wr_crc_ok, .wr_abort, .rel,
    .mem_we, .mem_waddr, .mem_wdata,
    .fill_pub, .fill_slot, .fill_desc,
    .end_pub, .end_slot, .end_desc,
    .ovf_evt, .drop_start, .drop_act, .occ_o(occ)
  );

  hrx_store #(.DEPTH(DEPTH)) u_st (
    .clk, .rst_n, .clr(cmd_reset),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data),
    .fill_pub, .fill_slot, .fill_desc,
    .end_pub, .end_slot, .end_desc,
    .rel, .head_slot(rslot), .head_ready, .head_desc
  );

  hrx_host #(.DEPTH(DEPTH)) u_hs (
    .clk, .rst_n, .clr(cmd_reset), .sel(bs_sel),
    .head_ready, .head_desc, .cmd_release, .irq_ack, .rd_en, .ovf_evt,
    .rel, .rslot, .rd_addr, .rx_count(cnt), .rx_status,
    .irq_pf(irq_pool_full), .irq_me(irq_msg_end), .irq_ov(irq_overflow),
    .shown, .rd_off
  );

  assign rx_count = cnt;
endmodule

// File: rtl/hrx_pool_chk.sv
`timescale 1ns/1ps
module hrx_pool_chk
  import hrx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int SW = $clog2(DEPTH / 4)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_reset,
  input logic             cmd_release,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic [5:0]       rx_count,
  input logic             irq_pf,
  input logic             irq_me,
  input logic             irq_ov,
  input bsel_t            sel,
  input logic [SW:0]      occ,
  input logic             shown,
  input logic [LEN_W-1:0] rd_off,
  input logic [SW-1:0]    rslot,
  input logic             mem_we,
  input logic             drop_start,
  input logic             drop_act
);
  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (rx_count == 0 && !irq_pf && !irq_me && !irq_ov)); // R12

  AST_ONE_DATA_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pf && irq_me)); // R5

  AST_DATA_IRQ_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pf || irq_me) |-> (shown && rx_count != 0)); // R5

  AST_PF_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pf |-> (rx_count == blk_bytes(sel))); // R4

  AST_ME_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_me |-> (rx_count != 0 && rx_count <= blk_bytes(sel))); // R3

  AST_SLOTS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (SW+1)'(slot_total(DEPTH, sel))); // R11

  AST_DROP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_act || drop_start) |-> !mem_we); // R8

  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_release && !shown && !cmd_reset) |=> $stable(rslot)); // R6

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (shown && rd_en && !cmd_release && !cmd_reset && (32'(rd_off) + 1 == 32'(rx_count)))
      |=> $stable(rd_data)); // R7
endmodule

bind hrx_pool hrx_pool_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_release(cmd_release),
  .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count),
  .irq_pf(irq_pool_full), .irq_me(irq_msg_end), .irq_ov(irq_overflow),
  .sel(bs_sel), .occ(occ), .shown(shown), .rd_off(rd_off), .rslot(rslot),
  .mem_we(mem_we), .drop_start(drop_start), .drop_act(drop_act)
);

// File: tb/hrx_pool_tb_top.sv
`timescale 1ns/1ps
module hrx_pool_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_bsize = 2'b00;
  logic       wr_valid = 1'b0, wr_last = 1'b0, wr_crc_ok = 1'b0, wr_abort = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cmd_release = 1'b0, cmd_reset = 1'b0, irq_ack = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [5:0] rx_count;
  logic [1:0] rx_status;
  logic       irq_pool_full, irq_msg_end, irq_overflow;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  hrx_pool dut_i (
    .clk, .rst_n, .cfg_bsize, .wr_valid, .wr_data, .wr_last, .wr_crc_ok, .wr_abort,
    .cmd_release, .cmd_reset, .irq_ack, .rd_en, .rd_data, .rx_count, .rx_status,
    .irq_pool_full, .irq_msg_end, .irq_overflow
  );

  task automatic chk_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(int n, int base, bit crc, bit abt);
    for (int i = 0; i < n; i++) begin
      wr_valid  = 1'b1;
      wr_data   = 8'((base + i) % 256);
      wr_last   = (i == n - 1);
      wr_crc_ok = crc;
      wr_abort  = abt;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_release();
    cmd_release = 1'b1; @(negedge clk); cmd_release = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_reset(logic [1:0] code);
    cfg_bsize = code; cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;
  endtask

  task automatic read_block(string tag, int n, int base);
    for (int i = 0; i < n; i++) begin
      chk_eq({tag, " R7 byte"}, int'(rd_data), (base + i) % 256);
      if (i < n - 1) pulse_rd();
    end
    pulse_rd();
    pulse_rd();
    chk_eq({tag, " R7 hold last"}, int'(rd_data), (base + n - 1) % 256);
  endtask

  task automatic expect_blk(string tag, bit pf, bit me, int cnt, int base);
    chk_eq({tag, " pool_full"}, int'(irq_pool_full), int'(pf));
    chk_eq({tag, " msg_end"}, int'(irq_msg_end), int'(me));
    chk_eq({tag, " count"}, int'(rx_count), cnt);
    read_block(tag, cnt, base);
  endtask

  task automatic t_reset_state();
    chk_eq("R1 pool_full", int'(irq_pool_full), 0);
    chk_eq("R1 msg_end", int'(irq_msg_end), 0);
    chk_eq("R1 overflow", int'(irq_overflow), 0);
    chk_eq("R1 count", int'(rx_count), 0);
    chk_eq("R1 status", int'(rx_status), 0);
  endtask

  task automatic t_short();
    send_frame(3, 8'h10, 1'b1, 1'b0);
    tick(2);
    chk_eq("R3 status", int'(rx_status), 2);
    expect_blk("R3 short", 1'b0, 1'b1, 3, 8'h10);
    pulse_ack();
    chk_eq("R10 msg_end cleared", int'(irq_msg_end), 0);
    chk_eq("R10 count kept", int'(rx_count), 3);
    chk_eq("R10 read pos kept", int'(rd_data), 8'h12);
    pulse_release();
    tick(2);
    chk_eq("R5 count after release", int'(rx_count), 0);
    pulse_release();          // nothing exposed: must be ignored
    tick(1);
    send_frame(2, 8'h40, 1'b0, 1'b1);
    tick(2);
    chk_eq("R6 status", int'(rx_status), 1);
    expect_blk("R6 after idle release", 1'b0, 1'b1, 2, 8'h40);
    pulse_release();
    tick(2);
  endtask

  task automatic t_long();
    send_frame(10, 8'h20, 1'b1, 1'b0);
    tick(3);
    expect_blk("R4 long b0", 1'b1, 1'b0, 4, 8'h20);
    pulse_ack();
    tick(3);
    chk_eq("R5 no irq before release pf", int'(irq_pool_full), 0);
    chk_eq("R5 no irq before release me", int'(irq_msg_end), 0);
    chk_eq("R5 same block count", int'(rx_count), 4);
    pulse_release();
    tick(2);
    expect_blk("R4 long b1", 1'b1, 1'b0, 4, 8'h24);
    pulse_release();
    tick(2);
    expect_blk("R4 long tail", 1'b0, 1'b1, 2, 8'h28);
    chk_eq("R4 tail status", int'(rx_status), 2);
    pulse_release();
    tick(2);
    chk_eq("R4 drained", int'(rx_count), 0);
  endtask

  task automatic t_exact();
    send_frame(8, 8'h50, 1'b0, 1'b0);
    tick(2);
    expect_blk("R4 exact b0", 1'b1, 1'b0, 4, 8'h50);
    pulse_release();
    tick(2);
    expect_blk("R4 exact end", 1'b0, 1'b1, 4, 8'h54);
    pulse_release();
    tick(2);
  endtask

  task automatic t_modes();
    cfg_bsize = 2'b01;        // no reset command: size stays 4
    tick(1);
    send_frame(6, 8'h60, 1'b1, 1'b0);
    tick(2);
    expect_blk("R2 unchanged size", 1'b1, 1'b0, 4, 8'h60);
    pulse_release();
    tick(2);
    expect_blk("R2 unchanged tail", 1'b0, 1'b1, 2, 8'h64);
    pulse_release();
    pulse_reset(2'b01);
    send_frame(6, 8'h70, 1'b1, 1'b0);
    tick(2);
    expect_blk("R2 size 8", 1'b0, 1'b1, 6, 8'h70);
    pulse_release();
    pulse_reset(2'b11);
    send_frame(40, 8'h00, 1'b1, 1'b0);
    tick(2);
    expect_blk("R2 size 32 b0", 1'b1, 1'b0, 32, 8'h00);
    pulse_release();
    tick(2);
    expect_blk("R2 size 32 end", 1'b0, 1'b1, 8, 8'h20);
    pulse_release();
    pulse_reset(2'b10);
    send_frame(16, 8'h90, 1'b1, 1'b0);
    tick(2);
    expect_blk("R2 size 16 exact", 1'b0, 1'b1, 16, 8'h90);
    pulse_release();
    tick(2);
    send_frame(17, 8'hB0, 1'b1, 1'b0);
    tick(2);
    expect_blk("R4 size 16 plus one b0", 1'b1, 1'b0, 16, 8'hB0);
    pulse_release();
    tick(2);
    expect_blk("R4 size 16 plus one end", 1'b0, 1'b1, 1, 8'hC0);
    pulse_release();
    tick(2);
  endtask

  task automatic t_drop();
    pulse_reset(2'b11);
    send_frame(20, 8'h80, 1'b1, 1'b0);
    send_frame(20, 8'hA0, 1'b1, 1'b0);
    send_frame(5, 8'hF0, 1'b1, 1'b0);
    tick(2);
    chk_eq("R8 overflow raised", int'(irq_overflow), 1);
    expect_blk("R8 first kept", 1'b0, 1'b1, 20, 8'h80);
    pulse_ack();
    chk_eq("R10 overflow cleared", int'(irq_overflow), 0);
    pulse_release();
    tick(2);
    expect_blk("R8 second kept", 1'b0, 1'b1, 20, 8'hA0);
    pulse_release();
    tick(3);
    chk_eq("R8 dropped frame absent count", int'(rx_count), 0);
    chk_eq("R8 dropped frame absent irq", int'(irq_msg_end), 0);
  endtask

  task automatic t_trunc();
    pulse_reset(2'b11);
    send_frame(70, 8'h00, 1'b1, 1'b0);
    tick(2);
    chk_eq("R9 overflow raised", int'(irq_overflow), 1);
    expect_blk("R9 first block", 1'b1, 1'b0, 32, 8'h00);
    pulse_ack();
    pulse_release();
    tick(2);
    chk_eq("R9 abort status", int'(rx_status), 3);
    expect_blk("R9 cut block", 1'b0, 1'b1, 32, 8'h20);
    pulse_release();
    tick(2);
  endtask

  task automatic t_wrap();
    pulse_reset(2'b00);
    for (int k = 0; k < 20; k++) begin
      send_frame(3, k * 8, 1'b1, 1'b0);
      tick(2);
      expect_blk("R11 wrap", 1'b0, 1'b1, 3, k * 8);
      pulse_release();
      tick(1);
    end
  endtask

  task automatic t_clear();
    pulse_reset(2'b00);
    send_frame(3, 8'h11, 1'b1, 1'b0);
    send_frame(3, 8'h22, 1'b1, 1'b0);
    tick(2);
    chk_eq("R12 before clear", int'(irq_msg_end), 1);
    pulse_reset(2'b00);
    chk_eq("R12 msg_end", int'(irq_msg_end), 0);
    chk_eq("R12 pool_full", int'(irq_pool_full), 0);
    chk_eq("R12 overflow", int'(irq_overflow), 0);
    chk_eq("R12 count", int'(rx_count), 0);
    tick(3);
    chk_eq("R12 old data gone", int'(rx_count), 0);
    send_frame(2, 8'h33, 1'b0, 1'b0);
    tick(2);
    expect_blk("R12 fresh frame", 1'b0, 1'b1, 2, 8'h33);
    pulse_release();
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset_state();
    t_short();
    t_long();
    t_exact();
    t_modes();
    t_drop();
    t_trunc();
    t_wrap();
    t_clear();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule